// File: doc/BRIEF.md
# Oscillator Calibration Counter

This block measures the frequency of one clock relative to another. The fast system clock defines a window of a programmed number of cycles, and during that window the block counts rising edges of a reference oscillator chosen from a small set. The count at the end of the window is the ratio between the two clocks, which firmware uses to estimate or trim an oscillator.

Firmware sets the window length, the reference code and the continuous bit, then issues a start pulse. A one-shot run holds busy high until the count is captured and then raises a sticky ready flag. In continuous mode the block re-arms itself at the end of every window, so busy stays high and firmware simply reads the latest count whenever ready is set. Reference inputs are asynchronous; each passes through its own synchronizer into the fast domain, and all control logic runs on the fast clock.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, busy_o, ready_o and count_o are all zero.
- R2: A start pulse sampled at edge S makes busy_o high from edge S on; with an effective window of N cycles the result is captured at edge S+N, and in one-shot mode busy_o falls at that same edge and not before.
- R3: Each reference passes through a two-flop synchronizer followed by one history flop; the counted event is a synchronized low-to-high transition, so the edge counted at edge S+j corresponds to the input level being high at edge S+j-2 and low at edge S+j-3, for j = 1..N.
- R4: Reference select codes: 0 low-frequency crystal, 1 low-frequency RC, 2 high-frequency crystal, 3 high-frequency RC, 4 auxiliary RC; codes 5 to 7 select nothing and give a count of zero.
- R5: ready_o is set at each capture and stays set until a one on ready_clr_i; a clear sampled on the same edge as a capture leaves ready_o set.
- R6: With cont_i high when a window ends, a new window of the same length starts at once, busy_o stays high and a fresh count is captured every N cycles; cont_i low at a window end returns the block to idle.
- R7: A start pulse during a running measurement discards it: the window restarts from the programmed length, the count restarts at zero and no capture occurs at the old end time.
- R8: count_o holds the last captured value until the next capture, including across ready clears and idle periods.
- R9: Window length and reference select are latched at start; changing them during a run does not affect the running measurement.
- R10: A programmed window length of zero behaves as a length of one.
- R11: The count saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that defines the window |
| rst_n | input | 1 | Active-low reset, synchronous release |
| ref_clk_i | input | 5 | Asynchronous reference oscillator inputs, indexed by select code |
| ref_sel_i | input | 3 | Reference select code |
| window_i | input | WIN_W | Window length in fast clock cycles |
| cont_i | input | 1 | Continuous re-arm enable |
| start_i | input | 1 | One-cycle start command |
| ready_clr_i | input | 1 | One-cycle clear of the ready flag |
| busy_o | output | 1 | Measurement in progress |
| count_o | output | CNT_W | Last captured reference edge count |
| ready_o | output | 1 | Sticky result-ready flag |

## Verification
The bench builds the block with an 8-bit window length and a 5-bit count, so a window of 100 cycles against a reference toggling every cycle drives the count past 31 and the saturation corner is reached in a few hundred cycles. With these widths the random runs cover every select code, including the three unused ones, with windows short enough that many measurements, a continuous sequence, a mid-run restart and the clear-versus-capture collision all fit in one short run.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

    // Number of selectable references and the select field width.
    localparam int OC_NUM_REF = 5;
    localparam int OC_SEL_W   = 3;

    // Reference select codes, decoded by the selector.
    typedef enum logic [OC_SEL_W-1:0] {
        OC_REF_LF_XTAL = 3'd0,
        OC_REF_LF_RC   = 3'd1,
        OC_REF_HF_XTAL = 3'd2,
        OC_REF_HF_RC   = 3'd3,
        OC_REF_AUX_RC  = 3'd4
    } oc_ref_e;

endpackage

// File: rtl/ocal_edge_sync.sv
// Brings one asynchronous reference into the fast domain and flags
// each synchronized low-to-high transition for one cycle.
module ocal_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // A synchronized edge needs at least one low and one high sample,
    // so two detections can never be adjacent.
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ocal_ref_select.sv
// One synchronizer per reference, then a decode of the latched select code.
module ocal_ref_select #(
    parameter int NUM_REF = ocal_pkg::OC_NUM_REF,
    parameter int SEL_W   = ocal_pkg::OC_SEL_W,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_clk_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               edge_o
);
    logic [NUM_REF-1:0] rise;

    for (genvar g = 0; g < NUM_REF; g++) begin : g_sync
        ocal_edge_sync #(.STAGES(STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ref_clk_i[g]),
            .rise_o  (rise[g])
        );
    end

    // Codes beyond the populated references decode to no source.
    always_comb begin
        edge_o = 1'b0;
        for (int i = 0; i < NUM_REF; i++) begin
            if (sel_i == SEL_W'(i)) edge_o = rise[i];
        end
    end

endmodule

// File: rtl/ocal_measure_core.sv
// Window timer, edge counter, result capture and ready flag.
module ocal_measure_core #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 20,
    parameter int SEL_W = ocal_pkg::OC_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             ready_clr_i,
    input  logic [WIN_W-1:0] window_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             edge_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ready_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

    typedef struct packed {
        logic             busy;
        logic             rdy;
        logic [WIN_W-1:0] len;
        logic [WIN_W-1:0] win;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
    } core_st_t;

    core_st_t s_d, s_q;

    logic             last_cyc;
    logic             capture;
    logic [CNT_W-1:0] cnt_next;
    logic [WIN_W-1:0] len_eff;

    always_comb begin
        s_d      = s_q;
        capture  = 1'b0;
        last_cyc = s_q.busy && (s_q.win == WIN_ONE);
        len_eff  = (window_i == '0) ? WIN_ONE : window_i;
        cnt_next = s_q.cnt;
        if (edge_i && (s_q.cnt != CNT_MAX)) cnt_next = s_q.cnt + 1'b1;

        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.len  = len_eff;
            s_d.win  = len_eff;
            s_d.sel  = sel_i;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            if (last_cyc) begin
                capture  = 1'b1;
                s_d.res  = cnt_next;
                s_d.cnt  = '0;
                s_d.win  = s_q.len;
                s_d.busy = cont_i;
            end else begin
                s_d.cnt = cnt_next;
                s_d.win = s_q.win - 1'b1;
            end
        end

        s_d.rdy = capture | (s_q.rdy & ~ready_clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel_o   = s_q.sel;
    assign busy_o  = s_q.busy;
    assign count_o = s_q.res;
    assign ready_o = s_q.rdy;

    assert_win_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.win != '0));

    assert_fall_has_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.rdy);

    assert_ready_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rdy) |-> $past(s_q.busy));

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |=> $stable(s_q.res));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (s_q.cnt == CNT_MAX) && !start_i && (s_q.win != WIN_ONE))
        |=> (s_q.cnt == CNT_MAX));

endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter #(
    parameter int WIN_W       = 16,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ocal_pkg::OC_NUM_REF-1:0] ref_clk_i,
    input  logic [ocal_pkg::OC_SEL_W-1:0]   ref_sel_i,
    input  logic [WIN_W-1:0]                window_i,
    input  logic                            cont_i,
    input  logic                            start_i,
    input  logic                            ready_clr_i,
    output logic                            busy_o,
    output logic [CNT_W-1:0]                count_o,
    output logic                            ready_o
);
    localparam int NUM_REF = ocal_pkg::OC_NUM_REF;
    localparam int SEL_W   = ocal_pkg::OC_SEL_W;

    logic [SEL_W-1:0] sel_q;
    logic             ref_edge;

    ocal_ref_select #(
        .NUM_REF (NUM_REF),
        .SEL_W   (SEL_W),
        .STAGES  (SYNC_STAGES)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk_i (ref_clk_i),
        .sel_i     (sel_q),
        .edge_o    (ref_edge)
    );

    ocal_measure_core #(
        .WIN_W (WIN_W),
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cont_i      (cont_i),
        .ready_clr_i (ready_clr_i),
        .window_i    (window_i),
        .sel_i       (ref_sel_i),
        .edge_i      (ref_edge),
        .sel_o       (sel_q),
        .busy_o      (busy_o),
        .count_o     (count_o),
        .ready_o     (ready_o)
    );

endmodule

// File: tb/sim_osc_cal_counter.sv
module sim_osc_cal_counter;
    localparam int WIN_W = 8;
    localparam int CNT_W = 5;
    localparam int NREF  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NREF-1:0]  ref_clk = '0;
    logic [2:0]       ref_sel = '0;
    logic [WIN_W-1:0] win = '0;
    logic             cont = 1'b0;
    logic             start = 1'b0;
    logic             clr = 1'b0;
    logic             busy;
    logic [CNT_W-1:0] count;
    logic             ready;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int per [NREF];
    int ph  [NREF];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    osc_cal_counter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .ref_sel_i(ref_sel),
        .window_i(win), .cont_i(cont), .start_i(start), .ready_clr_i(clr),
        .busy_o(busy), .count_o(count), .ready_o(ready)
    );

    function automatic bit lvl(input int i, input int k);
        return ((k + ph[i]) % per[i]) < (per[i] / 2);
    endfunction

    // Reference levels presented before edge number cyc.
    always @(negedge clk) begin
        for (int i = 0; i < NREF; i++) ref_clk[i] <= lvl(i, cyc);
    end

    // R3 / R4 / R11 model: synchronized rising edges counted over the window.
    function automatic int exp_cnt(input int sel, input int s, input int n);
        int c = 0;
        if (sel >= NREF) return 0;
        for (int j = 1; j <= n; j++)
            if (lvl(sel, s + j - 2) && !lvl(sel, s + j - 3)) c++;
        return (c > 31) ? 31 : c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic goto(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic clear_ready();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run_shot(input int sel, input int n);
        int s, ne;
        clear_ready();
        s = cyc; ne = (n == 0) ? 1 : n;
        ref_sel = 3'(sel); win = WIN_W'(n); cont = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        goto(s + ne);
        chk("R2 busy until capture", busy, 1);
        chk("R5 ready low before capture", ready, 0);
        @(negedge clk);
        chk("R2 idle after one-shot", busy, 0);
        chk("R5 ready at capture", ready, 1);
        chk(sel >= NREF ? "R4 unused code" : "R3 count", count, exp_cnt(sel, s, ne));
    endtask

    initial begin : main
        int s, s2, e;
        void'($urandom(32'h5EED_0C01));
        for (int i = 0; i < NREF; i++) begin
            per[i] = 2 + int'($urandom % 9);
            ph[i]  = int'($urandom % 16);
        end
        per[2] = 2;

        repeat (4) @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 ready reset", ready, 0);
        chk("R1 count reset", count, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // Every populated code and the unused codes.
        for (int sel = 0; sel < 8; sel++) run_shot(sel, 24);

        // Random mix.
        for (int it = 0; it < 30; it++)
            run_shot(int'($urandom % 8), 1 + int'($urandom % 40));

        // R10: zero length acts as one.
        run_shot(3, 0);
        run_shot(2, 1);

        // R11: saturation with a reference edge every other cycle.
        run_shot(2, 100);
        chk("R11 saturated", count, 31);

        // R8: result held over idle and over a clear.
        e = count;
        repeat (5) @(negedge clk);
        chk("R8 held idle", count, e);
        chk("R5 ready sticky", ready, 1);
        clear_ready();
        chk("R5 ready cleared", ready, 0);
        chk("R8 held over clear", count, e);

        // R5: clear on the capture edge loses to the capture.
        s = cyc; ref_sel = 3'd0; win = 8'd6; start = 1'b1;
        @(negedge clk); start = 1'b0;
        goto(s + 6);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R5 clear with capture", ready, 1);
        chk("R3 count with clear", count, exp_cnt(0, s, 6));

        // R9: configuration changed mid-run is ignored.
        clear_ready();
        s = cyc; ref_sel = 3'd1; win = 8'd10; start = 1'b1;
        @(negedge clk); start = 1'b0;
        ref_sel = 3'd3; win = 8'd3;
        goto(s + 4);
        chk("R9 window not shortened", busy, 1);
        chk("R9 no early ready", ready, 0);
        goto(s + 11);
        chk("R9 latched select", count, exp_cnt(1, s, 10));
        chk("R9 busy low", busy, 0);

        // R7: restart during a run.
        clear_ready();
        s = cyc; ref_sel = 3'd4; win = 8'd12; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        s2 = cyc; start = 1'b1;
        @(negedge clk); start = 1'b0;
        goto(s + 13);
        chk("R7 no capture at old end", ready, 0);
        chk("R7 still busy", busy, 1);
        goto(s2 + 13);
        chk("R7 restarted count", count, exp_cnt(4, s2, 12));
        chk("R7 ready after restart", ready, 1);

        // R6: continuous mode.
        clear_ready();
        s = cyc; ref_sel = 3'd0; win = 8'd9; cont = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        goto(s + 10);
        chk("R6 first count", count, exp_cnt(0, s, 9));
        chk("R6 busy stays", busy, 1);
        chk("R6 ready first", ready, 1);
        clear_ready();
        goto(s + 19);
        chk("R6 second count", count, exp_cnt(0, s + 9, 9));
        chk("R6 ready second", ready, 1);
        chk("R6 busy second", busy, 1);
        cont = 1'b0;
        goto(s + 28);
        chk("R6 third count", count, exp_cnt(0, s + 18, 9));
        chk("R6 stops when cleared", busy, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule